// File: doc/BRIEF.md
# DVB Energy Dispersal Descrambler

This block undoes the energy-dispersal randomisation that a DVB transmitter applies to a transport stream. It sits after error correction and takes one byte per cycle, with a valid flag, a packet-start flag and an error flag. Packets are 188 bytes long, and the first byte of each one is its sync byte. Every eighth packet begins a new randomisation group. That packet carries the inverted sync value B8 hex in place of the normal 47 hex.

A 15-stage pseudo-random generator with the polynomial 1 + X^14 + X^15 is loaded with a fixed seed whenever an inverted sync byte arrives. It then produces one keystream byte for every accepted byte that follows. Each keystream byte is XORed into a payload byte. Normal sync bytes still step the generator, so the sequence stays continuous across a group, but they are passed through unchanged. Inverted sync bytes are rewritten to 47 hex, so every output packet carries the same sync value.

Until the first inverted sync byte after reset, nothing can be descrambled. In that state bytes pass through untouched and a flag marks them as not descrambled. Each output appears one cycle after its input byte, with the packet-start and error flags delayed to match.

Top module: `ed_descrambler`

## Requirements
- R1: While reset is held and right after it is released, out_valid and out_descr are 0.
- R2: Every accepted byte (in_valid = 1) produces out_valid = 1 exactly one clock cycle later, together with its processed byte.
- R3: A byte with in_sop = 1 and value B8 hex is output as 47 hex with out_descr = 1, and it locks the block.
- R4: After lock, each byte with in_sop = 0 is output as in_data XOR a keystream byte. The keystream is defined as follows:
  - Each keystream bit is stage 14 XOR stage 15 of a 15-stage shift register.
  - After each bit, the register shifts by one, with that bit entering stage 1.
  - The register is seeded with 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0 for stages 1 to 15.
  - The first bit produced for a byte is XORed into its most significant bit (bit 7).
  - The register steps eight times for every accepted byte after the inverted sync byte, and does not step for the inverted sync byte itself.
- R5: After lock, a byte with in_sop = 1 and any value other than B8 hex is output unchanged, and the keystream still advances by eight bits for it.
- R6: Before the first inverted sync byte after reset, every byte is output unchanged with out_descr = 0.
- R7: Every inverted sync byte reloads the seed, even in the middle of a group, so the following payload uses the keystream from its start.
- R8: Cycles with in_valid = 0 give out_valid = 0 one cycle later and do not advance the keystream.
- R9: out_sop and out_err equal in_sop and in_err of the same byte, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is a packet's sync byte |
| in_data | input | 8 | Input byte |
| in_err | input | 1 | Error flag for the input packet |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is a sync byte |
| out_data | output | 8 | Descrambled byte |
| out_err | output | 1 | Delayed error flag |
| out_descr | output | 1 | Byte comes from a locked (descrambled) stream |

## Verification
Every result of this block is due one cycle after the input byte is taken. That covers the byte, the start and error flags, and the descrambled flag. Idle cycles also show up one cycle later as a low valid. The bench drives each byte at the falling edge and samples the outputs one time unit after the next rising edge. It checks every byte there against a bitwise model of the shift register that it steps itself, and it drops the valid flag right after the capturing edge so that no unmodelled byte can enter.

// File: rtl/ed_pkg.sv
package ed_pkg;
  localparam int DATA_W = 8;
  localparam int PRBS_W = 15;

  typedef struct packed {
    logic [PRBS_W-1:0] state;
    logic [DATA_W-1:0] ks;
  } ks_step_t;

  // One byte worth of generator steps; state bit 0 is stage 1.
  function automatic ks_step_t prbs_step8(input logic [PRBS_W-1:0] s_in);
    ks_step_t r;
    logic [PRBS_W-1:0] s;
    logic fb;
    s = s_in;
    r.ks = '0;
    for (int i = 0; i < DATA_W; i++) begin
      fb = s[13] ^ s[14];
      r.ks[DATA_W-1-i] = fb;
      s = {s[PRBS_W-2:0], fb};
    end
    r.state = s;
    return r;
  endfunction
endpackage

// File: rtl/ed_prbs.sv
module ed_prbs
  import ed_pkg::*;
#(
  parameter logic [PRBS_W-1:0] SEED = 15'h00A9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [DATA_W-1:0] ks
);
  logic [PRBS_W-1:0] state;
  ks_step_t          nxt;

  assign nxt = prbs_step8(state);
  assign ks  = nxt.ks;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= SEED;
    else if (adv)  state <= nxt.state;
  end

  // R7
  reload_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == SEED);
  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state));
endmodule

// File: rtl/ed_sync_track.sv
module ed_sync_track
  import ed_pkg::*;
#(
  parameter logic [DATA_W-1:0] SYNC_INV = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic              sync_hit,
  output logic              inv_hit,
  output logic              locked
);
  assign sync_hit = in_valid && in_sop;
  assign inv_hit  = sync_hit && (in_data == SYNC_INV);

  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b0;
    else if (inv_hit) locked <= 1'b1;
  end

  // R3
  lock_on_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit |=> locked);
endmodule

// File: rtl/ed_descrambler.sv
module ed_descrambler
  import ed_pkg::*;
#(
  parameter logic [DATA_W-1:0] SYNC_NORM = 8'h47,
  parameter logic [DATA_W-1:0] SYNC_INV  = 8'hB8,
  parameter logic [PRBS_W-1:0] SEED      = 15'h00A9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_err,
  output logic              out_valid,
  output logic              out_sop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic              out_descr
);
  logic              sync_hit, inv_hit, trk_locked;
  logic              ks_load, ks_adv;
  logic [DATA_W-1:0] ks_byte;
  logic [DATA_W-1:0] data_d;

  ed_sync_track #(.SYNC_INV(SYNC_INV)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .sync_hit(sync_hit), .inv_hit(inv_hit),
    .locked(trk_locked)
  );

  assign ks_load = inv_hit;
  assign ks_adv  = in_valid && trk_locked && !inv_hit;

  ed_prbs #(.SEED(SEED)) u_prbs (
    .clk(clk), .rst_n(rst_n), .load(ks_load), .adv(ks_adv), .ks(ks_byte)
  );

  always_comb begin
    if (inv_hit)                     data_d = SYNC_NORM;
    else if (sync_hit || !trk_locked) data_d = in_data;
    else                             data_d = in_data ^ ks_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_err   <= 1'b0;
      out_descr <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= in_valid && in_sop;
      out_err   <= in_valid && in_err;
      out_descr <= in_valid && (trk_locked || inv_hit);
      if (in_valid) out_data <= data_d;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  inv_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit |=> (out_data == SYNC_NORM) && out_descr);
  // R6
  prelock_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trk_locked && !inv_hit) |=> (out_data == $past(in_data)) && !out_descr);
endmodule

// File: tb/ed_descrambler_bench.sv
module ed_descrambler_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_sop, out_err, out_descr;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [15:1] r;
  logic        lk;
  logic [31:0] rnd = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  ed_descrambler u_ed_descrambler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .in_err(in_err), .out_valid(out_valid),
    .out_sop(out_sop), .out_data(out_data), .out_err(out_err),
    .out_descr(out_descr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic seed_model();
    r = '0;
    r[1] = 1'b1; r[4] = 1'b1; r[6] = 1'b1; r[8] = 1'b1;
  endtask

  function automatic logic [7:0] model_byte();
    logic [7:0] k;
    for (int b = 7; b >= 0; b--) begin
      k[b] = r[14] ^ r[15];
      r = {r[14:1], k[b]};
    end
    return k;
  endfunction

  function automatic logic [7:0] next_rnd();
    rnd = rnd * 32'd1103515245 + 32'd12345;
    return rnd[23:16];
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e, input string dtag);
    logic [7:0] exp;
    logic [7:0] kk;
    string tag;
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_data = d; in_err = e;
    if (s && d == 8'hB8) begin
      seed_model(); lk = 1'b1; exp = 8'h47; tag = "R3";
    end else if (!lk) begin
      exp = d; tag = "R6";
    end else if (s) begin
      kk = model_byte(); exp = d; tag = "R5";
    end else begin
      kk = model_byte(); exp = d ^ kk; tag = dtag;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R2", out_valid, 1);
    chk(out_data === exp, tag, out_data, exp);
    chk(out_descr === lk, lk ? "R3" : "R6", out_descr, lk);
    chk(out_sop === s && out_err === e, "R9", {out_sop, out_err}, {s, e});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sop = 1'b1; in_data = 8'hB8;
    @(posedge clk);
    #1;
    chk(out_valid === 1'b0, "R8", out_valid, 0);
  endtask

  task automatic send_packet(input logic [7:0] sync, input logic e, input string dtag, input int gap);
    send_byte(sync, 1'b1, e, dtag);
    for (int i = 1; i < 188; i++) begin
      if (gap != 0 && (i % gap) == 0) idle_cycle();
      send_byte(next_rnd(), 1'b0, e, dtag);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    lk = 1'b0;
    seed_model();
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid === 1'b0 && out_descr === 1'b0, "R1", {out_valid, out_descr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(out_valid === 1'b0 && out_descr === 1'b0, "R1", {out_valid, out_descr}, 0);
  endtask

  task automatic t_prelock();
    send_packet(8'h47, 1'b0, "R6", 0);
    send_packet(8'h47, 1'b1, "R6", 0);
  endtask

  task automatic t_group();
    send_packet(8'hB8, 1'b0, "R4", 0);
    for (int p = 0; p < 7; p++) send_packet(8'h47, p[0], "R4", 0);
  endtask

  task automatic t_gaps();
    send_packet(8'hB8, 1'b1, "R8", 5);
    send_packet(8'h47, 1'b0, "R8", 7);
  endtask

  task automatic t_regroup();
    send_packet(8'h47, 1'b0, "R7", 0);
    send_packet(8'hB8, 1'b0, "R7", 0);
    send_packet(8'h47, 1'b1, "R7", 0);
  endtask

  initial begin
    t_reset();
    t_prelock();
    t_group();
    t_gaps();
    t_regroup();
    t_group();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule